// File: doc/BRIEF.md
# Quad Serial Wiper-Code Register Bank

This block is the digital control core of a four-channel, 64-step programmable resistor. A host shifts 8-bit words into it over a three-wire serial link made of a serial clock, a data input and an active-low chip select. Each word carries a 2-bit channel number in its first two bits and a 6-bit tap code in its last six. When chip select rises, the code is written into that channel's holding latch. Each latch drives a one-hot tap-select vector for the resistor ladder, which lies outside the block.

The far end of the shift register drives a serial data output. The output changes on falling serial-clock edges, so several blocks can be chained on one chip select with no address decoding. The chain then behaves as one long shift register, and on the chip-select edge each block keeps the last eight bits it holds.

An asynchronous active-low reset presets every latch to midscale (code 32) and clears the shift register. A shutdown input opens every channel's A terminal, shorts every wiper to B and turns off all taps. The latches keep their contents during shutdown and still accept writes. On release, each channel returns to whatever its latch holds at that moment.

The serial inputs are sampled on the system clock `clk`. A small state machine frames each word:
- `SER_IDLE` goes to `SER_SHIFT` when chip select goes low.
- `SER_SHIFT` goes to `SER_COMMIT` when chip select goes high.
- `SER_COMMIT` lasts one cycle. It issues the latch write, then goes to `SER_SHIFT` if chip select is already low again, or to `SER_IDLE` if it is not.

Top module: `quad_wiper_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, every channel latch holds 32. Each channel's tap vector then has only bit 32 set, `sdo_o` is 0, and `a_open_o` and `w_short_o` are 0.
- R2: On each rising `sclk_i` edge while `cs_n_i` is low, `sdi_i` is shifted into bit 0 of an 8-bit register and the older bits move toward bit 7. On the rising edge of `cs_n_i`, bits 7:6 of that register select the channel (0 to 3) and bits 5:0 give the code. The first bit sent is therefore the channel MSB, and only the last eight bits shifted count.
- R3: A write changes only the addressed channel's latch. The other three latches keep their values.
- R4: No latch changes until `cs_n_i` rises. Serial-clock edges while `cs_n_i` is high do not alter the shift register.
- R5: On each falling `sclk_i` edge while `cs_n_i` is low, `sdo_o` takes bit 7 of the shift register, which is the bit shifted in eight rising edges earlier. `sdo_o` changes at no other time.
- R6: Outside shutdown, each channel c drives `tap_sel_o[c*64 + code]` high and its other 63 tap bits low.
- R7: While `pwr_down_i` is high, every bit of `a_open_o` and `w_short_o` is 1 and all of `tap_sel_o` is 0.
- R8: Shutdown leaves the latches unchanged. On release, every channel shows the code it held before shutdown.
- R9: Writes made during shutdown are stored and appear when shutdown is released.
- R10: Reset clears the shift register. A chip-select pulse after reset with no clocks therefore writes code 0 to channel 0, and `sdo_o` gives 0 for the first eight falling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in, MSB first |
| cs_n_i | input | 1 | Active-low chip select; its rising edge commits the word |
| pwr_down_i | input | 1 | Shutdown request, active high |
| sdo_o | output | 1 | Serial data out for chaining |
| tap_sel_o | output | 256 | One-hot tap select, 64 bits per channel, channel 0 in the low bits |
| a_open_o | output | 4 | Per-channel A-terminal open control |
| w_short_o | output | 4 | Per-channel wiper-to-B short control |

## Verification
On every cycle, the embedded assertions check four things:
- a latch write occurs only right after chip select has been seen high;
- `sdo_o` moves only after a sampled falling serial-clock edge;
- unaddressed latches hold still;
- each channel's tap vector is one-hot outside shutdown and fully safe inside it.

Only the bench's scenarios can show that the decoded address and code are right, and that chained words come out bit-exact on `sdo_o` eight edges late. The same holds for codes written in shutdown appearing on release, and for a commit with no clocks after reset writing zero to channel 0.

// File: rtl/wb_pkg.sv
package wb_pkg;
    typedef enum logic [1:0] {
        SER_IDLE   = 2'd0,
        SER_SHIFT  = 2'd1,
        SER_COMMIT = 2'd2
    } ser_state_e;
endpackage

// File: rtl/wb_serial_front.sv
module wb_serial_front
    import wb_pkg::*;
#(
    parameter int AW = 2,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_i,
    input  logic          sdi_i,
    input  logic          cs_n_i,
    output logic          sdo_o,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [CW-1:0] wr_code_o
);
    localparam int WW = AW + CW;

    ser_state_e    state_q, state_d;
    logic          sclk_q;
    logic [WW-1:0] shreg_q;
    logic          sclk_rise, sclk_fall;

    assign sclk_rise = sclk_i & ~sclk_q;
    assign sclk_fall = ~sclk_i & sclk_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SER_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SER_IDLE:   if (!cs_n_i) state_d = SER_SHIFT;
            SER_SHIFT:  if (cs_n_i)  state_d = SER_COMMIT;
            SER_COMMIT: state_d = cs_n_i ? SER_IDLE : SER_SHIFT;
            default:    state_d = SER_IDLE;
        endcase
    end

    // datapath: edge history, shift register, chain output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            shreg_q <= '0;
            sdo_o   <= 1'b0;
        end else begin
            sclk_q <= sclk_i;
            if (state_q == SER_SHIFT && !cs_n_i && sclk_rise)
                shreg_q <= {shreg_q[WW-2:0], sdi_i};
            if (state_q == SER_SHIFT && !cs_n_i && sclk_fall)
                sdo_o <= shreg_q[WW-1];
        end
    end

    // outputs per state
    always_comb begin
        wr_en_o   = 1'b0;
        wr_addr_o = shreg_q[WW-1 -: AW];
        wr_code_o = shreg_q[CW-1:0];
        unique case (state_q)
            SER_COMMIT: wr_en_o = 1'b1;
            default:    wr_en_o = 1'b0;
        endcase
    end

    AST_WR_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> $past(cs_n_i)); // R4

    AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo_o) |-> $past(sclk_fall)); // R5
endmodule

// File: rtl/wb_latch_bank.sv
module wb_latch_bank #(
    parameter int NCH = 4,
    parameter int AW  = 2,
    parameter int CW  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [AW-1:0]     wr_addr_i,
    input  logic [CW-1:0]     wr_code_i,
    output logic [NCH*CW-1:0] codes_o
);
    localparam logic [CW-1:0] MID = CW'(1 << (CW - 1));

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [CW-1:0] code_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                    code_q <= MID;
            else if (wr_en_i && wr_addr_i == AW'(g))       code_q <= wr_code_i;
        end
        assign codes_o[g*CW +: CW] = code_q;

        AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en_i && wr_addr_i == AW'(g)) |=> $stable(codes_o[g*CW +: CW])); // R3
    end
endmodule

// File: rtl/wb_tap_drive.sv
module wb_tap_drive #(
    parameter int CW = 6
) (
    input  logic [CW-1:0]       code_i,
    input  logic                pwr_down_i,
    output logic [(1<<CW)-1:0]  tap_o,
    output logic                a_open_o,
    output logic                w_short_o
);
    localparam int NPOS = 1 << CW;

    for (genvar p = 0; p < NPOS; p++) begin : g_pos
        assign tap_o[p] = !pwr_down_i && (code_i == CW'(p));
    end
    assign a_open_o  = pwr_down_i;
    assign w_short_o = pwr_down_i;
endmodule

// File: rtl/quad_wiper_ctrl.sv
module quad_wiper_ctrl #(
    parameter int NCH = 4,
    parameter int CW  = 6,
    localparam int AW   = $clog2(NCH),
    localparam int NPOS = 1 << CW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk_i,
    input  logic                sdi_i,
    input  logic                cs_n_i,
    input  logic                pwr_down_i,
    output logic                sdo_o,
    output logic [NCH*NPOS-1:0] tap_sel_o,
    output logic [NCH-1:0]      a_open_o,
    output logic [NCH-1:0]      w_short_o
);
    logic              wr_en;
    logic [AW-1:0]     wr_addr;
    logic [CW-1:0]     wr_code;
    logic [NCH*CW-1:0] codes;

    wb_serial_front #(.AW(AW), .CW(CW)) u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (sclk_i),
        .sdi_i     (sdi_i),
        .cs_n_i    (cs_n_i),
        .sdo_o     (sdo_o),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_code_o (wr_code)
    );

    wb_latch_bank #(.NCH(NCH), .AW(AW), .CW(CW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_code_i (wr_code),
        .codes_o   (codes)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_drv
        wb_tap_drive #(.CW(CW)) u_drv (
            .code_i     (codes[c*CW +: CW]),
            .pwr_down_i (pwr_down_i),
            .tap_o      (tap_sel_o[c*NPOS +: NPOS]),
            .a_open_o   (a_open_o[c]),
            .w_short_o  (w_short_o[c])
        );

        AST_TAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
            !pwr_down_i |-> $countones(tap_sel_o[c*NPOS +: NPOS]) == 1); // R6

        AST_SHDN_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
            pwr_down_i |-> (tap_sel_o[c*NPOS +: NPOS] == '0) && a_open_o[c] && w_short_o[c]); // R7
    end
endmodule

// File: tb/quad_wiper_ctrl_tb.sv
module quad_wiper_ctrl_tb;
    localparam int NCH = 4;
    localparam int NPOS = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdi = 1'b0, cs_n = 1'b1, pd = 1'b0;
    logic sdo;
    logic [NCH*NPOS-1:0] tap;
    logic [NCH-1:0] aop, wsh;

    always #5 clk = ~clk;

    quad_wiper_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdi_i(sdi), .cs_n_i(cs_n),
        .pwr_down_i(pd), .sdo_o(sdo), .tap_sel_o(tap), .a_open_o(aop), .w_short_o(wsh)
    );

    // reference model
    logic [5:0] exp_code [NCH];
    logic [7:0] exp_sr;
    logic       exp_sdo;
    logic       exp_pd;

    // scoreboard
    logic [NCH*NPOS-1:0] q_tap [$];
    logic [NCH-1:0]      q_ao  [$];
    logic                q_sdo [$];
    string               q_tag [$];
    int n_vec = 0, n_bad = 0;
    bit done = 0;

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) exp_code[c] = 6'd32;
        exp_sr = 8'h00; exp_sdo = 1'b0;
    endtask

    task automatic push_exp(input string tag);
        logic [NCH*NPOS-1:0] t;
        t = '0;
        if (!exp_pd)
            for (int c = 0; c < NCH; c++) t[c*NPOS + int'(exp_code[c])] = 1'b1;
        q_tap.push_back(t);
        q_ao.push_back({NCH{exp_pd}});
        q_sdo.push_back(exp_sdo);
        q_tag.push_back(tag);
        repeat (2) @(negedge clk);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (q_tag.size() > 0) begin
                logic [NCH*NPOS-1:0] et;
                logic [NCH-1:0] ea;
                logic es;
                string tg;
                et = q_tap.pop_front(); ea = q_ao.pop_front();
                es = q_sdo.pop_front(); tg = q_tag.pop_front();
                n_vec++;
                if (tap !== et) begin
                    n_bad++;
                    $display("FAIL %s tap_sel actual=%h expected=%h", tg, tap, et);
                end else if (aop !== ea || wsh !== ea) begin
                    n_bad++;
                    $display("FAIL %s a_open/w_short actual=%b/%b expected=%b", tg, aop, wsh, ea);
                end else if (sdo !== es) begin
                    n_bad++;
                    $display("FAIL %s sdo actual=%b expected=%b", tg, sdo, es);
                end
            end
        end
    end

    task automatic send_bit(input logic b, input string tag);
        @(negedge clk);
        if (sclk && !cs_n) exp_sdo = exp_sr[7];
        sclk = 1'b0; sdi = b;
        repeat (2) @(negedge clk);
        push_exp(tag);
        sclk = 1'b1;
        if (!cs_n) exp_sr = {exp_sr[6:0], b};
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_low();
        @(negedge clk); cs_n = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic cs_high(input string tag);
        @(negedge clk); cs_n = 1'b1;
        exp_code[exp_sr[7:6]] = exp_sr[5:0];
        @(negedge clk); sclk = 1'b0;
        repeat (4) @(negedge clk);
        push_exp(tag);
    endtask

    task automatic send_frame(input logic [15:0] bits, input int n, input string tag);
        cs_low();
        for (int i = n - 1; i >= 0; i--) send_bit(bits[i], tag);
        cs_high(tag);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        exp_pd = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        push_exp("R1 reset midscale");

        // R2/R6: channel 0 code 5
        send_frame(16'h0005, 8, "R2 R6 ch0 write");
        // R3: other channels written one by one
        send_frame(16'h00FF, 8, "R3 ch3 code 63");
        send_frame(16'h0040, 8, "R3 ch1 code 0");
        send_frame(16'h0091, 8, "R3 ch2 code 17");

        // R4: shifting alone does not update; then commit
        cs_low();
        for (int i = 7; i >= 0; i--) send_bit(8'h6A >> i, "R4 shift no commit");
        push_exp("R4 before cs rise");
        cs_high("R4 after cs rise");

        // R4: serial clocks while deselected are ignored
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); sdi = i[0]; sclk = 1'b1;
            repeat (3) @(negedge clk); sclk = 1'b0;
            repeat (3) @(negedge clk);
        end
        push_exp("R4 clocks with cs high");
        cs_low();
        cs_high("R4 shreg untouched");

        // R5/R2: chained 16-bit frame, second byte lands here
        send_frame(16'h9CC7, 16, "R5 R2 daisy chain");

        // R7/R8/R9: shutdown
        @(negedge clk); pd = 1'b1; exp_pd = 1'b1;
        repeat (2) @(negedge clk);
        push_exp("R7 shutdown outputs");
        send_frame(16'h0023, 8, "R9 write during shutdown");
        @(negedge clk); pd = 1'b0; exp_pd = 1'b0;
        repeat (2) @(negedge clk);
        push_exp("R8 R9 restore on release");

        // R1/R10: reset mid-run, then empty commit
        do_reset();
        push_exp("R1 reset again");
        cs_low();
        cs_high("R10 empty commit writes ch0=0");
        send_frame(16'h00B0, 8, "R10 sdo zeros after reset");
        send_frame(16'h00E9, 8, "R5 sdo old word");

        repeat (6) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule